// File: doc/BRIEF.md
# Wide Cell Ingress Buffer

This block receives fixed-size cells from user logic on a 160-bit bus that carries 20 octets per clock. The sender holds a valid level high for every cycle of a cell and drops it for at least one cycle between cells. Each cell is written into an internal FIFO. It becomes visible on a drain port only once its run of valid cycles has ended with the length that the configured cell size calls for.

Backpressure is advisory. After the sender sees it, the sender may finish the cell in progress and send one more whole cell. For this reason the block raises backpressure while the free space, counting words of a cell still being received, is below two cells' worth. A run of the wrong length is thrown away and leaves a sticky error flag. A word that meets a full FIFO is dropped, its cell is thrown away, and a sticky overflow flag is set. Stored cells are never overwritten.

Top module: `cell_ingress`

## Requirements
- R1: After a synchronous active-low reset, drain_valid, backpressure, len_err and overflow are all low.
- R2: cell_size selects the cell length. Code 0 is 75 octets and code 1 is 79 octets, both 4 words. Code 2 is 83 octets and code 3 is 91 octets, both 5 words. A run of exactly that many valid cycles is delivered on the drain port word by word in arrival order, with drain_last high only on the final word.
- R3: A received cell first shows on drain_valid after the clock edge that samples the first low cycle of cell_valid following the cell.
- R4: A single low cycle of cell_valid is enough to separate two cells, and both are delivered.
- R5: A valid run shorter or longer than the configured word count delivers no words and sets len_err, which stays high until reset.
- R6: backpressure is high exactly when DEPTH minus the words held is below twice the configured word count. Words held include the words of a cell still in progress.
- R7: A word that arrives while DEPTH words are held is dropped and sets overflow, which stays high until reset. The cell it belongs to is discarded, and previously stored cells are delivered intact.
- R8: One word leaves per cycle in which drain_valid and drain_ready are both high. While drain_ready is low, the head word and drain_last hold.
- R9: A sender that finishes the current cell plus at most one more cell after seeing backpressure never causes an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cell_size | input | 2 | Cell size code (0:75, 1:79, 2:83, 3:91 octets) |
| cell_data | input | 160 | Incoming cell word |
| cell_valid | input | 1 | High for every cycle of a cell |
| drain_ready | input | 1 | Consumer takes the head word |
| drain_valid | output | 1 | A committed word is available |
| drain_data | output | 160 | Head word |
| drain_last | output | 1 | Head word ends its cell |
| backpressure | output | 1 | Free space below two cells |
| len_err | output | 1 | Sticky: a run of the wrong length was seen |
| overflow | output | 1 | Sticky: a word was dropped on a full FIFO |

## Verification
The hardest case to reach is a word landing exactly on a full FIFO. Only a sender that ignores backpressure while the drain is stalled can get there. The bench stalls the drain and pushes four 5-word cells into a 16-word FIFO, so the fourth cell breaks partway through. It then drains and counts the delivered cells. A separate run plays a sender that uses its full allowance against a slow, irregular drain. That drives the FIFO right up to the reserve edge without crossing it.

// File: rtl/cell_ingress_pkg.sv
// Shared definitions for the wide cell ingress buffer.
// Assumes one bus word carries OCTETS_PER_WORD octets.
package cell_ingress_pkg;

    localparam int unsigned OCTETS_PER_WORD = 20;

    typedef enum logic [1:0] {
        SZ_75 = 2'd0,
        SZ_79 = 2'd1,
        SZ_83 = 2'd2,
        SZ_91 = 2'd3
    } cell_size_e;

    // Octet count of a cell for a size code
    function automatic int unsigned cell_octets(cell_size_e s);
        case (s)
            SZ_75:   return 75;
            SZ_79:   return 79;
            SZ_83:   return 83;
            default: return 91;
        endcase
    endfunction

    // Bus words needed for one cell (octets rounded up to whole words)
    function automatic int unsigned cell_words(cell_size_e s);
        return (cell_octets(s) + OCTETS_PER_WORD - 1) / OCTETS_PER_WORD;
    endfunction

endpackage

// File: rtl/cell_run_tracker.sv
// Tracks one valid run at a time. It counts the words of the run, requests
// a FIFO write for each word up to the configured count, and on the first low
// cycle of valid decides whether the run is committed or discarded.
// Assumes words_per_cell is stable while a run is in progress.
module cell_run_tracker #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [CW-1:0] words_per_cell,
    input  logic          drop,
    output logic          wr_req,
    output logic          wr_last,
    output logic          commit,
    output logic          discard,
    output logic          len_err
);
    logic [CW-1:0] cnt;
    logic          prev_valid;
    logic          dropped_q;
    logic          run_end;

    // Write requests stop once the configured count is reached
    assign wr_req  = in_valid && (cnt < words_per_cell);
    assign wr_last = (cnt == words_per_cell - CW'(1));
    assign run_end = !in_valid && prev_valid;
    assign commit  = run_end && (cnt == words_per_cell) && !dropped_q;
    assign discard = run_end && !commit;

    // Run counter (saturating one past the cell length) and drop memory
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            prev_valid <= 1'b0;
            dropped_q  <= 1'b0;
        end else begin
            prev_valid <= in_valid;
            if (in_valid) begin
                if (cnt <= words_per_cell) cnt <= cnt + CW'(1);
                if (drop) dropped_q <= 1'b1;
            end else begin
                cnt       <= '0;
                dropped_q <= 1'b0;
            end
        end
    end

    // Sticky length-error flag
    always_ff @(posedge clk) begin
        if (!rst_n)                                         len_err <= 1'b0;
        else if (run_end && (cnt != words_per_cell))        len_err <= 1'b1;
    end

    AST_COMMIT_NEEDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(in_valid && wr_last)); // R3
    AST_LEN_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        len_err |=> len_err); // R5

endmodule

// File: rtl/cell_store.sv
// FIFO with a tentative write pointer. Words of a cell in progress are
// written ahead of the committed pointer and are only released to the read
// side on commit. A discard rolls the tentative pointer back.
// Assumes DEPTH is a power of two and commit/discard never coincide with a write.
module cell_store #(
    parameter  int DATA_W = 160,
    parameter  int DEPTH  = 16,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_last,
    input  logic              commit,
    input  logic              discard,
    input  logic              rd_take,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_last,
    output logic [PW-1:0]     occupancy,
    output logic              drop,
    output logic              ovf
);
    logic [DATA_W:0] mem [DEPTH];
    logic [PW-1:0]   wr_tmp;
    logic [PW-1:0]   wr_ptr;
    logic [PW-1:0]   rd_ptr;
    logic            full;

    assign occupancy = wr_tmp - rd_ptr;
    assign full      = (occupancy == PW'(DEPTH));
    assign drop      = wr_req && full;
    assign rd_valid  = (wr_ptr != rd_ptr);
    assign {rd_last, rd_data} = mem[rd_ptr[AW-1:0]];

    // Storage write of an accepted word with its end-of-cell marker
    always_ff @(posedge clk) begin
        if (wr_req && !full) mem[wr_tmp[AW-1:0]] <= {wr_last, wr_data};
    end

    // Tentative, committed and read pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_tmp <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_req && !full) wr_tmp <= wr_tmp + PW'(1);
            if (commit)          wr_ptr <= wr_tmp;
            if (discard)         wr_tmp <= wr_ptr;
            if (rd_take && rd_valid) rd_ptr <= rd_ptr + PW'(1);
        end
    end

    // Sticky overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n)    ovf <= 1'b0;
        else if (drop) ovf <= 1'b1;
    end

    AST_OCC_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy <= PW'(DEPTH)); // R7
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf); // R7
    AST_DISCARD_ROLLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        discard |=> (PW'(wr_tmp - wr_ptr) <= PW'(1))); // R5
    AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_take) |=> (rd_valid && $stable(rd_data) && $stable(rd_last))); // R8

endmodule

// File: rtl/bp_gen.sv
// Backpressure decision. Raised while free space is below two whole cells,
// so that a sender may finish its current cell and send one more.
// Assumes occupancy already includes words of a cell in progress.
module bp_gen #(
    parameter  int DEPTH = 16,
    parameter  int CW    = 3,
    localparam int PW    = $clog2(DEPTH) + 1
) (
    input  logic [PW-1:0] occupancy,
    input  logic [CW-1:0] words_per_cell,
    output logic          bp
);
    logic [PW:0] free_w;
    logic [PW:0] reserve_w;

    // Compare free space against a two-cell reserve
    always_comb begin
        free_w    = (PW+1)'(DEPTH) - {1'b0, occupancy};
        reserve_w = (PW+1)'({words_per_cell, 1'b0});
        bp        = (free_w < reserve_w);
    end

endmodule

// File: rtl/cell_ingress.sv
// Top of the wide cell ingress buffer: decodes the size code, tracks valid
// runs, stores cells and produces advisory backpressure.
// Assumes cell_size is static while cells are arriving and DEPTH >= 2 cells.
module cell_ingress
    import cell_ingress_pkg::*;
#(
    parameter  int DATA_W    = 160,
    parameter  int DEPTH     = 16,
    parameter  int MAX_WORDS = 5,
    localparam int CW        = $clog2(MAX_WORDS + 2),
    localparam int PW        = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cell_size,
    input  logic [DATA_W-1:0] cell_data,
    input  logic              cell_valid,
    input  logic              drain_ready,
    output logic              drain_valid,
    output logic [DATA_W-1:0] drain_data,
    output logic              drain_last,
    output logic              backpressure,
    output logic              len_err,
    output logic              overflow
);
    logic [CW-1:0] words_per_cell;
    logic          wr_req, wr_last, commit, discard, drop;
    logic [PW-1:0] occupancy;

    assign words_per_cell = CW'(cell_words(cell_size_e'(cell_size)));

    cell_run_tracker #(.CW(CW)) i_tracker (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (cell_valid),
        .words_per_cell (words_per_cell),
        .drop           (drop),
        .wr_req         (wr_req),
        .wr_last        (wr_last),
        .commit         (commit),
        .discard        (discard),
        .len_err        (len_err)
    );

    cell_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_req    (wr_req),
        .wr_data   (cell_data),
        .wr_last   (wr_last),
        .commit    (commit),
        .discard   (discard),
        .rd_take   (drain_ready),
        .rd_valid  (drain_valid),
        .rd_data   (drain_data),
        .rd_last   (drain_last),
        .occupancy (occupancy),
        .drop      (drop),
        .ovf       (overflow)
    );

    bp_gen #(.DEPTH(DEPTH), .CW(CW)) i_bp (
        .occupancy      (occupancy),
        .words_per_cell (words_per_cell),
        .bp             (backpressure)
    );

    AST_BP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (occupancy == PW'(DEPTH)) |-> backpressure); // R6

endmodule

// File: tb/test_cell_ingress.sv
`timescale 1ns/1ps
module test_cell_ingress;
    localparam int DEPTH = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   cell_size = 2'd0;
    logic [159:0] cell_data = '0;
    logic         cell_valid = 1'b0;
    logic         drain_ready = 1'b0;
    logic         drain_valid, drain_last, backpressure, len_err, overflow;
    logic [159:0] drain_data;

    always #2.5 clk = ~clk;

    cell_ingress i_cell_ingress (
        .clk(clk), .rst_n(rst_n), .cell_size(cell_size), .cell_data(cell_data),
        .cell_valid(cell_valid), .drain_ready(drain_ready), .drain_valid(drain_valid),
        .drain_data(drain_data), .drain_last(drain_last), .backpressure(backpressure),
        .len_err(len_err), .overflow(overflow)
    );

    int checks = 0;
    int failures = 0;
    int seen_cells = 0;
    int cyc = 0;
    int rdy_mode = 0;
    bit bp_seen = 0;

    // Reference model state
    logic [160:0] q_done[$];
    logic [160:0] q_tent[$];
    int m_cnt = 0, m_words = 4, occ_pre = 0;
    bit m_prev = 0, m_drop = 0, m_len = 0, m_ovf = 0;

    // Behavioural model, updated on each rising edge
    always @(posedge clk) begin
        m_words = cell_size[1] ? 5 : 4;
        if (!rst_n) begin
            q_done.delete(); q_tent.delete();
            m_cnt = 0; m_prev = 0; m_drop = 0; m_len = 0; m_ovf = 0;
        end else begin
            occ_pre = q_done.size() + q_tent.size();
            if (drain_ready && q_done.size() > 0) void'(q_done.pop_front());
            if (cell_valid) begin
                if (m_cnt < m_words) begin
                    if (occ_pre == DEPTH) begin m_drop = 1; m_ovf = 1; end
                    else q_tent.push_back({(m_cnt == m_words - 1), cell_data});
                end
                if (m_cnt <= m_words) m_cnt++;
            end else begin
                if (m_prev) begin
                    if (m_cnt == m_words && !m_drop)
                        foreach (q_tent[k]) q_done.push_back(q_tent[k]);
                    if (m_cnt != m_words) m_len = 1;
                end
                q_tent.delete(); m_cnt = 0; m_drop = 0;
            end
            m_prev = cell_valid;
        end
    end

    // Count cells leaving the drain port
    always @(posedge clk)
        if (rst_n && drain_valid && drain_ready && drain_last) seen_cells++;

    task automatic check_eq(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_word(logic [159:0] act, logic [159:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL R2 drain_data actual=%h expected=%h", act, exp);
        end
    endtask

    // Compare every output against the model
    task automatic compare();
        int held;
        held = q_done.size() + q_tent.size();
        check_eq("R3", "drain_valid", drain_valid, q_done.size() != 0);
        if (q_done.size() != 0) begin
            check_word(drain_data, q_done[0][159:0]);       // R2, R8
            check_eq("R2", "drain_last", drain_last, q_done[0][160]);
        end
        check_eq("R6", "backpressure", backpressure, (DEPTH - held) < 2 * m_words);
        check_eq("R5", "len_err", len_err, m_len);
        check_eq("R7", "overflow", overflow, m_ovf);
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
        if (backpressure) bp_seen = 1;
        cyc++;
        case (rdy_mode)
            0:       drain_ready = 1'b1;
            1:       drain_ready = 1'b0;
            2:       drain_ready = (cyc % 3 != 0);
            default: drain_ready = (cyc % 4 == 0);
        endcase
    endtask

    function automatic logic [159:0] mk_word(int c, int i);
        return {5{c[15:0], i[15:0]}};
    endfunction

    task automatic send_run(int id, int len);
        for (int i = 0; i < len; i++) begin
            cell_valid = 1'b1; cell_data = mk_word(id, i); tick();
        end
        cell_valid = 1'b0; cell_data = '0; tick();
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(); tick(); rst_n = 1'b1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int base;
        bit extra_used;
        do_reset();
        // R1: reset state
        check_eq("R1", "drain_valid after reset", drain_valid, 0);
        check_eq("R1", "backpressure after reset", backpressure, 0);
        check_eq("R1", "len_err after reset", len_err, 0);
        check_eq("R1", "overflow after reset", overflow, 0);

        // R2/R4: 4-word cells back to back with one-cycle gaps
        rdy_mode = 0; cell_size = 2'd0; tick();
        base = seen_cells;
        for (int c = 0; c < 3; c++) send_run(c, 4);
        idle(8);
        check_eq("R4", "cells with single-cycle gaps", seen_cells - base, 3);

        // R2/R8: 5-word cells with an irregular drain
        rdy_mode = 2; cell_size = 2'd3; tick();
        base = seen_cells;
        for (int c = 10; c < 14; c++) send_run(c, 5);
        rdy_mode = 0; idle(12);
        check_eq("R8", "cells under stalling drain", seen_cells - base, 4);
        cell_size = 2'd2; tick();
        send_run(20, 5); idle(4);

        // R5: short and long runs discarded
        cell_size = 2'd1; tick();
        base = seen_cells;
        send_run(30, 3);
        send_run(31, 6);
        send_run(32, 4);
        idle(8);
        check_eq("R5", "only the good cell delivered", seen_cells - base, 1);
        check_eq("R5", "len_err sticky", len_err, 1);

        // R7: overflow with a stalled drain
        do_reset();
        check_eq("R1", "len_err cleared by reset", len_err, 0);
        cell_size = 2'd2; rdy_mode = 1; tick();
        base = seen_cells;
        for (int c = 40; c < 44; c++) send_run(c, 5);
        check_eq("R7", "overflow set", overflow, 1);
        rdy_mode = 0; idle(25);
        check_eq("R7", "stored cells intact", seen_cells - base, 3);

        // R9: sender uses its full allowance against a slow drain
        do_reset();
        cell_size = 2'd3; rdy_mode = 3; tick();
        base = seen_cells; bp_seen = 0; extra_used = 0;
        for (int c = 50; c < 62; c++) begin
            if (bp_seen) begin
                if (extra_used) begin
                    while (backpressure) tick();
                    bp_seen = 0; extra_used = 0;
                end else extra_used = 1;
            end
            send_run(c, 5);
        end
        rdy_mode = 0; idle(30);
        check_eq("R9", "no overflow when obeying", overflow, 0);
        check_eq("R9", "all cells delivered", seen_cells - base, 12);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule